// File: doc/BRIEF.md
# CCD Line Window and Clamp-Mask Generator

This block follows the readout of a CCD sensor one pixel clock at a time. It keeps a pixel counter that restarts on every line strobe and a line counter that restarts on every frame strobe. From these counters it produces three per-pixel windows. The first is horizontal blanking. The second is the black-level clamp pulse. The third is an optional preblank that blanks the digital output. Each window is set by an inclusive start and end pixel count. Loading an end below its start turns that window off.

The clamp pulse must fall only on valid optical-black pixels of real lines. The usual case is the 48 trailing optical-black pixels at the end of each line. In the default geometry these follow 28 dummy pixels, 4 leading optical-black pixels and the effective pixels. The clamp is held low in five cases:
- the line is not marked valid;
- vertical blanking is active;
- a sensor-gate line is running;
- the line number matches one of four enabled mask entries;
- preblank is active on the same pixel.

The mask lets chosen lines skip the clamp without reprogramming the clamp window. The default frame has 10 optical-black lines at the front and 2 at the back. The caller marks these lines, together with the image lines, as valid.

Top module: `ccd_window_gen`

## Requirements
- R1: While reset is low, all three window outputs and both counters read 0.
- R2: The pixel counter reads 0 in the cycle after a line strobe. Otherwise it rises by 1 each cycle and holds at its all-ones maximum.
- R3: The line counter reads 0 in the cycle after a frame strobe. A frame strobe wins over a line strobe in the same cycle. Otherwise each line strobe raises the count by 1, and the count holds at its all-ones maximum.
- R4: The blanking output is high in the cycle after the pixel counter holds a value inside its inclusive [start, end] window.
- R5: A window whose end is below its start never asserts its output. This applies to blanking, clamp and preblank.
- R6: The preblank output follows its window only while the preblank enable input is 1. While the enable is 0, preblank stays low.
- R7: The clamp and preblank outputs are never high together. A pixel inside both windows gets preblank and no clamp.
- R8: The clamp stays low for any pixel sampled while line-valid is 0, vertical blanking is 1 or sensor-gate is 1.
- R9: The clamp stays low on a line whose count equals the line field of any mask entry with its enable bit set. Entry i occupies bits [i*LINE_W +: LINE_W] of the mask bus. Disabled entries have no effect, and the blanking output is never touched by the mask.
- R10: Outside the conditions of R5, R7, R8 and R9, the clamp output is high in the cycle after the pixel counter holds a value inside the clamp window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start_i | input | 1 | Line strobe, restarts the pixel count |
| frame_start_i | input | 1 | Frame strobe, restarts the line count |
| line_valid_i | input | 1 | Current line carries valid optical-black pixels |
| vblank_i | input | 1 | Vertical blanking in progress |
| sgate_i | input | 1 | Sensor-gate line timing in progress |
| hblk_start_i | input | PIX_W | First blanking pixel |
| hblk_end_i | input | PIX_W | Last blanking pixel |
| clamp_start_i | input | PIX_W | First clamp pixel |
| clamp_end_i | input | PIX_W | Last clamp pixel |
| pblk_en_i | input | 1 | Preblank enable |
| pblk_start_i | input | PIX_W | First preblank pixel |
| pblk_end_i | input | PIX_W | Last preblank pixel |
| mask_en_i | input | NMASK | Enable bit per mask entry |
| mask_line_i | input | NMASK*LINE_W | Line numbers of the mask entries |
| hblk_o | output | 1 | Horizontal blanking window |
| clamp_o | output | 1 | Black-level clamp pulse |
| pblk_o | output | 1 | Digital output preblank |
| pix_cnt_o | output | PIX_W | Current pixel count |
| line_cnt_o | output | LINE_W | Current line count |

## Verification
The counters change on the clock edge that samples a strobe, so a count is visible one cycle after its strobe. Each window output is registered from the count held during the previous cycle, together with the level inputs and mask match sampled on that same edge. Every output is therefore due exactly one edge after the pixel it describes.

The bench mirrors this timing. Right after each rising edge it computes the expected outputs from its own copy of the counters and from the inputs it is holding. It then advances its counters and compares at the following falling edge. Inputs change only at falling edges, after that comparison.

// File: rtl/ccdw_pkg.sv
package ccdw_pkg;
  localparam int DEF_DUMMY_PIX      = 28;
  localparam int DEF_LEAD_OB_PIX    = 4;
  localparam int DEF_TRAIL_OB_PIX   = 48;
  localparam int DEF_FRONT_OB_LINES = 10;
  localparam int DEF_BACK_OB_LINES  = 2;

  typedef struct packed {
    logic hblk;
    logic clamp;
    logic pblk;
  } win_flags_t;

  // inclusive window test; an inverted window is empty
  function automatic logic in_window(input logic [31:0] pos,
                                     input logic [31:0] first,
                                     input logic [31:0] last);
    return (last >= first) && (pos >= first) && (pos <= last);
  endfunction
endpackage

// File: rtl/ccdw_counters.sv
module ccdw_counters #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              frame_start,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt
);
  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_cnt  <= '0;
      line_cnt <= '0;
    end else begin
      if (line_start)
        pix_cnt <= '0;
      else if (pix_cnt != PIX_MAX)
        pix_cnt <= pix_cnt + 1'b1;

      if (frame_start)
        line_cnt <= '0;
      else if (line_start && line_cnt != LINE_MAX)
        line_cnt <= line_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ccdw_line_mask.sv
module ccdw_line_mask #(
  parameter int LINE_W = 12,
  parameter int NMASK  = 4
) (
  input  logic [LINE_W-1:0]       line_cnt,
  input  logic [NMASK-1:0]        mask_en,
  input  logic [NMASK*LINE_W-1:0] mask_line,
  output logic                    mask_hit
);
  logic [NMASK-1:0] match;

  for (genvar i = 0; i < NMASK; i++) begin : g_entry
    assign match[i] = mask_en[i] && (mask_line[i*LINE_W +: LINE_W] == line_cnt);
  end

  assign mask_hit = |match;
endmodule

// File: rtl/ccdw_window.sv
module ccdw_window
  import ccdw_pkg::*;
#(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_cnt,
  input  logic             clamp_line_ok,
  input  logic [PIX_W-1:0] hblk_start,
  input  logic [PIX_W-1:0] hblk_end,
  input  logic [PIX_W-1:0] clamp_start,
  input  logic [PIX_W-1:0] clamp_end,
  input  logic             pblk_en,
  input  logic [PIX_W-1:0] pblk_start,
  input  logic [PIX_W-1:0] pblk_end,
  output logic             clamp_raw,
  output logic             pblk_raw,
  output win_flags_t       flags_q
);
  win_flags_t flags_d;

  assign clamp_raw = in_window(32'(pix_cnt), 32'(clamp_start), 32'(clamp_end));
  assign pblk_raw  = pblk_en && in_window(32'(pix_cnt), 32'(pblk_start), 32'(pblk_end));

  always_comb begin
    flags_d.hblk  = in_window(32'(pix_cnt), 32'(hblk_start), 32'(hblk_end));
    flags_d.pblk  = pblk_raw;
    // preblank takes the pixel; clamp only on clean lines
    flags_d.clamp = clamp_raw && clamp_line_ok && !pblk_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/ccd_window_gen.sv
module ccd_window_gen
  import ccdw_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 12,
  parameter int NMASK  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    line_start_i,
  input  logic                    frame_start_i,
  input  logic                    line_valid_i,
  input  logic                    vblank_i,
  input  logic                    sgate_i,
  input  logic [PIX_W-1:0]        hblk_start_i,
  input  logic [PIX_W-1:0]        hblk_end_i,
  input  logic [PIX_W-1:0]        clamp_start_i,
  input  logic [PIX_W-1:0]        clamp_end_i,
  input  logic                    pblk_en_i,
  input  logic [PIX_W-1:0]        pblk_start_i,
  input  logic [PIX_W-1:0]        pblk_end_i,
  input  logic [NMASK-1:0]        mask_en_i,
  input  logic [NMASK*LINE_W-1:0] mask_line_i,
  output logic                    hblk_o,
  output logic                    clamp_o,
  output logic                    pblk_o,
  output logic [PIX_W-1:0]        pix_cnt_o,
  output logic [LINE_W-1:0]       line_cnt_o
);
  // named internal events, visible to the bound checker
  logic       mask_hit;
  logic       clamp_line_ok;
  logic       clamp_raw;
  logic       pblk_raw;
  win_flags_t flags_q;

  ccdw_counters #(.PIX_W(PIX_W), .LINE_W(LINE_W)) cnt_i (
    .clk(clk), .rst_n(rst_n),
    .line_start(line_start_i), .frame_start(frame_start_i),
    .pix_cnt(pix_cnt_o), .line_cnt(line_cnt_o)
  );

  ccdw_line_mask #(.LINE_W(LINE_W), .NMASK(NMASK)) mask_i (
    .line_cnt(line_cnt_o), .mask_en(mask_en_i),
    .mask_line(mask_line_i), .mask_hit(mask_hit)
  );

  assign clamp_line_ok = line_valid_i && !vblank_i && !sgate_i && !mask_hit;

  ccdw_window #(.PIX_W(PIX_W)) win_i (
    .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt_o),
    .clamp_line_ok(clamp_line_ok),
    .hblk_start(hblk_start_i), .hblk_end(hblk_end_i),
    .clamp_start(clamp_start_i), .clamp_end(clamp_end_i),
    .pblk_en(pblk_en_i), .pblk_start(pblk_start_i), .pblk_end(pblk_end_i),
    .clamp_raw(clamp_raw), .pblk_raw(pblk_raw), .flags_q(flags_q)
  );

  assign hblk_o  = flags_q.hblk;
  assign clamp_o = flags_q.clamp;
  assign pblk_o  = flags_q.pblk;
endmodule

// File: rtl/ccdw_checker.sv
module ccdw_checker #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_start_i,
  input logic              frame_start_i,
  input logic              line_valid_i,
  input logic              vblank_i,
  input logic              sgate_i,
  input logic              pblk_en_i,
  input logic [PIX_W-1:0]  hblk_start_i,
  input logic [PIX_W-1:0]  hblk_end_i,
  input logic              mask_hit,
  input logic [PIX_W-1:0]  pix_cnt_o,
  input logic [LINE_W-1:0] line_cnt_o,
  input logic              hblk_o,
  input logic              clamp_o,
  input logic              pblk_o
);
  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!hblk_o && !clamp_o && !pblk_o && pix_cnt_o == '0 && line_cnt_o == '0));

  assert_pix_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_i |=> pix_cnt_o == '0);

  assert_pix_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start_i && pix_cnt_o != PIX_MAX) |=> pix_cnt_o == $past(pix_cnt_o) + 1'b1);

  assert_frame_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> line_cnt_o == '0);

  assert_empty_hblk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hblk_end_i < hblk_start_i) |=> !hblk_o);

  assert_pblk_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pblk_en_i |=> !pblk_o);

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(clamp_o && pblk_o));

  assert_clamp_line_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_valid_i || vblank_i || sgate_i) |=> !clamp_o);

  assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_hit |=> !clamp_o);
endmodule

bind ccd_window_gen ccdw_checker #(.PIX_W(PIX_W), .LINE_W(LINE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .line_start_i(line_start_i),
  .frame_start_i(frame_start_i), .line_valid_i(line_valid_i),
  .vblank_i(vblank_i), .sgate_i(sgate_i), .pblk_en_i(pblk_en_i),
  .hblk_start_i(hblk_start_i), .hblk_end_i(hblk_end_i),
  .mask_hit(mask_hit), .pix_cnt_o(pix_cnt_o), .line_cnt_o(line_cnt_o),
  .hblk_o(hblk_o), .clamp_o(clamp_o), .pblk_o(pblk_o)
);

// File: tb/ccd_window_gen_tb_top.sv
module ccd_window_gen_tb_top;
  import ccdw_pkg::*;
  localparam int PW = 12;
  localparam int LW = 12;
  localparam int NM = 4;
  localparam int PMAX = (1 << PW) - 1;
  localparam int LMAX = (1 << LW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 0, frame_start = 0, line_valid = 0, vblank = 0, sgate = 0;
  logic [PW-1:0] hs = 0, he = 0, cs = 0, ce = 0, ps = 0, pe = 0;
  logic pblk_en = 0;
  logic [NM-1:0] men = 0;
  logic [NM*LW-1:0] mline = 0;
  logic hblk, clamp, pblk;
  logic [PW-1:0] pix;
  logic [LW-1:0] line;

  int n_checks = 0, n_fail = 0;
  int m_pix = 0, m_line = 0;
  bit e_hblk, e_clamp, e_pblk;
  string clamp_tag, hblk_tag, pblk_tag;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  ccd_window_gen #(.PIX_W(PW), .LINE_W(LW), .NMASK(NM)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_start_i(line_start), .frame_start_i(frame_start),
    .line_valid_i(line_valid), .vblank_i(vblank), .sgate_i(sgate),
    .hblk_start_i(hs), .hblk_end_i(he), .clamp_start_i(cs), .clamp_end_i(ce),
    .pblk_en_i(pblk_en), .pblk_start_i(ps), .pblk_end_i(pe),
    .mask_en_i(men), .mask_line_i(mline),
    .hblk_o(hblk), .clamp_o(clamp), .pblk_o(pblk), .pix_cnt_o(pix), .line_cnt_o(line)
  );

  function automatic bit covers(int p, int lo, int hi);
    if (lo > hi) return 0;
    return (p >= lo) && (p <= hi);
  endfunction

  function automatic bit masked_line(int ln);
    for (int i = 0; i < NM; i++)
      if (men[i] && int'(mline[i*LW +: LW]) == ln) return 1;
    return 0;
  endfunction

  task automatic check(int got, int exp, string tag, string what);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d (pix %0d line %0d)",
               tag, what, got, exp, m_pix, m_line);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // one pixel: expected outputs from the model count, then advance the model
  task automatic tick();
    bit in_c, in_p, line_bad, msk;
    @(posedge clk);
    in_c = covers(m_pix, int'(cs), int'(ce));
    in_p = pblk_en && covers(m_pix, int'(ps), int'(pe));
    line_bad = !line_valid || vblank || sgate;
    msk = masked_line(m_line);
    e_hblk = covers(m_pix, int'(hs), int'(he));
    e_pblk = in_p;
    e_clamp = in_c && !in_p && !line_bad && !msk;
    hblk_tag = (he < hs) ? "R5" : "R4";
    pblk_tag = (pe < ps) ? "R5" : "R6";
    if (ce < cs) clamp_tag = "R5";
    else if (in_c && in_p) clamp_tag = "R7";
    else if (in_c && line_bad) clamp_tag = "R8";
    else if (in_c && msk) clamp_tag = "R9";
    else clamp_tag = "R10";
    if (frame_start) m_line = 0;
    else if (line_start && m_line != LMAX) m_line++;
    if (line_start) m_pix = 0;
    else if (m_pix != PMAX) m_pix++;
    @(negedge clk);
    check(int'(pix), m_pix, "R2", "pixel count");
    check(int'(line), m_line, "R3", "line count");
    check(int'(hblk), int'(e_hblk), hblk_tag, "hblk");
    check(int'(pblk), int'(e_pblk), pblk_tag, "pblk");
    check(int'(clamp), int'(e_clamp), clamp_tag, "clamp");
    check(int'(clamp && pblk), 0, "R7", "clamp with pblk");
  endtask

  task automatic run_line(int len, bit fs);
    line_start = 1; frame_start = fs;
    tick();
    line_start = 0; frame_start = 0;
    for (int k = 1; k < len; k++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    int plen;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(int'(hblk), 0, "R1", "hblk in reset");
    check(int'(clamp), 0, "R1", "clamp in reset");
    check(int'(pblk), 0, "R1", "pblk in reset");
    check(int'(pix), 0, "R1", "pixel count in reset");
    check(int'(line), 0, "R1", "line count in reset");
    rst_n = 1;

    // default geometry frame: dummy + lead OB + 64 active + trailing OB
    plen = DEF_DUMMY_PIX + DEF_LEAD_OB_PIX + 64 + DEF_TRAIL_OB_PIX;
    hs = 0; he = PW'(DEF_DUMMY_PIX + DEF_LEAD_OB_PIX - 1);
    cs = PW'(plen - DEF_TRAIL_OB_PIX); ce = PW'(plen - 1);
    pblk_en = 1; ps = 0; pe = PW'(DEF_DUMMY_PIX - 1);
    men = 4'b0101; mline = {12'd0, 12'd40, 12'd0, 12'd3};  // R9: line 3 masked, entry 1 off
    line_valid = 1;
    for (int l = 0; l < DEF_FRONT_OB_LINES + 4 + DEF_BACK_OB_LINES; l++)
      run_line(plen, l == 0);
    // R8: vertical blanking and sensor-gate lines
    vblank = 1; run_line(plen, 0); vblank = 0;
    sgate = 1;  run_line(plen, 0); sgate = 0;
    line_valid = 0; run_line(plen, 0); line_valid = 1;
    // R7: preblank overlapping the clamp window
    ps = cs + 8; pe = cs + 20; run_line(plen, 0);
    pblk_en = 0; run_line(plen, 0);   // R6
    // R5: inverted windows
    he = 2; hs = 10; ce = cs - 1; pblk_en = 1; pe = 1; ps = 5;
    run_line(plen, 0);

    // random lines
    for (int r = 0; r < 40; r++) begin
      int len;
      len = 40 + int'($urandom_range(120));
      hs = PW'($urandom_range(150)); he = PW'($urandom_range(150));
      cs = PW'($urandom_range(150)); ce = PW'($urandom_range(150));
      ps = PW'($urandom_range(150)); pe = PW'($urandom_range(150));
      pblk_en = 1'($urandom_range(1));
      line_valid = ($urandom_range(3) != 0);
      vblank = ($urandom_range(7) == 0);
      sgate = ($urandom_range(7) == 0);
      men = 4'($urandom_range(15));
      for (int i = 0; i < NM; i++) mline[i*LW +: LW] = LW'($urandom_range(12));
      run_line(len, $urandom_range(9) == 0);
    end

    // R2: pixel counter saturation
    line_valid = 0;
    run_line(PMAX + 8, 0);
    // R3: line counter saturation and frame priority
    line_start = 1; frame_start = 1; tick(); frame_start = 0;
    for (int k = 0; k < LMAX + 6; k++) tick();
    frame_start = 1; tick();
    line_start = 0; frame_start = 0; tick();
    check(int'(line), 0, "R3", "line count after frame strobe");

    done = 1;
    summary();
  end
endmodule